// File: doc/BRIEF.md
# Configurable Serial Word Loader

This block lets a processor load control words into a small set of external devices over a simple three-line serial path: serial clock, serial data and one select line per device. Software first writes a control word that chooses the target device, the bit order, the edge on which the device samples data, and whether the word is 16 or 24 bits long. It then fills two data registers in any order and writes the start register. The block shifts the word out at a clock rate divided down from the system clock. It holds the chosen device's select line for the whole word and then gives that device a one-clock latch pulse.

The same control word also drives the clock and data lines of a separate two-wire bus directly, so software can bit-bang that bus. A busy output covers each transfer from the first bit through the latch pulse. A start that arrives during a transfer is dropped. Each accepted start sends whatever the data registers hold at that moment, so repeating a word needs only another start write.

Top module: `ser_word_loader`

## Requirements
- R1: After reset, busy is low, no select line or latch pulse is active, sclk is low, and both two-wire bus lines (bus_scl, bus_sda) are high.
- R2: Register addresses: 0 is control, 1 is the low data register (wr_data[15:0]), 2 is the high data register (wr_data[15:8] becomes word bits 23:16), and 3 is start. The two data registers may be written in either order before a start.
- R3: Control word layout: bit 0 selects LSB-first, bit 1 selects falling-edge sampling, bit 2 selects a 24-bit word, bit 3 drives bus_scl, bit 4 drives bus_sda, and bits 15:8 hold the device index.
- R4: MSB-first sends word bit N-1 first and bit 0 last. LSB-first sends bit 0 first and bit N-1 last. A 16-bit word is bits 15:0 of the held word.
- R5: While idle, sclk rests at the level named by the edge bit (low for rising-edge sampling, high for falling-edge sampling). Each bit lasts 2*HALF_DIV clocks. sdata changes only on the non-sampling edge and stays stable while sclk is at its active level.
- R6: A transfer produces exactly N sampling edges, where N is 16 or 24 according to control bit 2.
- R7: The select line of the indexed device is high for exactly 2*N*HALF_DIV clocks per transfer and every other select line stays low. An index of NUM_DEV or more asserts no select line.
- R8: On the clock right after its select line falls, the same device receives a latch pulse exactly one clock wide. An out-of-range index produces no latch pulse.
- R9: busy is high for exactly 2*N*HALF_DIV+1 clocks per transfer, ending with the latch clock.
- R10: A start write while busy is high starts nothing: no extra transfer follows, and the current one keeps its word and its length.
- R11: Each accepted start sends the data registers' current contents, so repeated starts resend the same word.
- R12: bus_scl and bus_sda follow control bits 3 and 4 one clock after a control write, and are not affected by transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| busy | output | 1 | Transfer in progress, including the latch clock |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| dev_en | output | NUM_DEV | Per-device select lines, active high |
| dev_latch | output | NUM_DEV | Per-device one-clock latch pulses |
| bus_scl | output | 1 | Manually driven two-wire bus clock line |
| bus_sda | output | 1 | Manually driven two-wire bus data line |

## Verification
The bench builds the block with HALF_DIV=2 and NUM_DEV=3. The short bit period keeps every 24-bit word to about a hundred clocks, so many transfers fit in one run. It also keeps the exact busy and select widths easy to predict. With three devices, index 3 is a legal field value but names no device, which exercises the out-of-range path. Transfers cover both bit orders, both sampling edges, both word lengths, data registers written high-first, a resend with no new data, and a start issued in the middle of a word.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_DLO  = 2'd1;
  localparam logic [1:0] ADR_DHI  = 2'd2;
  localparam logic [1:0] ADR_GO   = 2'd3;

  localparam int CB_LSB_FIRST   = 0;
  localparam int CB_SAMPLE_FALL = 1;
  localparam int CB_LEN24       = 2;
  localparam int CB_MAN_SCL     = 3;
  localparam int CB_MAN_SDA     = 4;

  localparam int WORD_BITS = 24;

  typedef struct packed {
    logic [7:0] dev;
    logic       lsb_first;
    logic       sample_fall;
    logic       len24;
  } xfer_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LATCH} eng_state_t;

  function automatic logic pick_bit(input logic [WORD_BITS-1:0] w,
                                    input logic [4:0] k,
                                    input logic lsb,
                                    input logic len24);
    logic [4:0] idx;
    idx = lsb ? k : ((len24 ? 5'd23 : 5'd15) - k);
    return w[idx];
  endfunction
endpackage

// File: rtl/swl_regfile.sv
module swl_regfile
  import swl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [15:0]          wr_data,
  output xfer_cfg_t            cfg,
  output logic [WORD_BITS-1:0] word,
  output logic                 man_scl,
  output logic                 man_sda,
  output logic                 start
);
  logic [15:0] lo_q;
  logic [7:0]  hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      man_scl <= 1'b1;
      man_sda <= 1'b1;
      start   <= 1'b0;
    end else begin
      start <= wr_en && (wr_addr == ADR_GO);
      if (wr_en) begin
        case (wr_addr)
          ADR_CTRL: begin
            cfg.lsb_first   <= wr_data[CB_LSB_FIRST];
            cfg.sample_fall <= wr_data[CB_SAMPLE_FALL];
            cfg.len24       <= wr_data[CB_LEN24];
            cfg.dev         <= wr_data[15:8];
            man_scl         <= wr_data[CB_MAN_SCL];
            man_sda         <= wr_data[CB_MAN_SDA];
          end
          ADR_DLO: lo_q <= wr_data;
          ADR_DHI: hi_q <= wr_data[15:8];
          default: ;
        endcase
      end
    end
  end

  assign word = {hi_q, lo_q};

  // R12
  man_line_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_CTRL) |=> (man_scl == $past(wr_data[CB_MAN_SCL]) &&
                                        man_sda == $past(wr_data[CB_MAN_SDA])));
endmodule

// File: rtl/swl_timebase.sv
module swl_timebase #(
  parameter int HALF_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // R5
  half_period_range_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/swl_engine.sv
module swl_engine
  import swl_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  xfer_cfg_t            cfg,
  input  logic [WORD_BITS-1:0] word,
  input  logic                 tick,
  output logic                 run,
  output logic                 busy,
  output logic                 sclk,
  output logic                 sdata,
  output logic [NUM_DEV-1:0]   dev_en,
  output logic [NUM_DEV-1:0]   dev_latch
);
  eng_state_t           state;
  logic                 phase_b;
  logic [4:0]           bit_cnt;
  logic                 lsb_q, fall_q, len24_q;
  logic [WORD_BITS-1:0] word_q;
  logic [NUM_DEV-1:0]   new_sel;
  logic                 last_bit;
  logic [4:0]           next_cnt;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
    assign new_sel[g] = (cfg.dev == 8'(g));
  end

  assign last_bit = (bit_cnt == (len24_q ? 5'd23 : 5'd15));
  assign next_cnt = bit_cnt + 5'd1;
  assign run      = (state == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      sclk      <= 1'b0;
      sdata     <= 1'b0;
      dev_en    <= '0;
      dev_latch <= '0;
      phase_b   <= 1'b0;
      bit_cnt   <= '0;
      lsb_q     <= 1'b0;
      fall_q    <= 1'b0;
      len24_q   <= 1'b0;
      word_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          sclk      <= cfg.sample_fall;
          dev_latch <= '0;
          if (start) begin
            state   <= ST_SHIFT;
            busy    <= 1'b1;
            lsb_q   <= cfg.lsb_first;
            fall_q  <= cfg.sample_fall;
            len24_q <= cfg.len24;
            word_q  <= word;
            bit_cnt <= '0;
            phase_b <= 1'b0;
            sdata   <= pick_bit(word, 5'd0, cfg.lsb_first, cfg.len24);
            dev_en  <= new_sel;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!phase_b) begin
              phase_b <= 1'b1;
              sclk    <= ~fall_q;
            end else if (last_bit) begin
              state     <= ST_LATCH;
              sclk      <= fall_q;
              dev_latch <= dev_en;
              dev_en    <= '0;
            end else begin
              bit_cnt <= next_cnt;
              phase_b <= 1'b0;
              sclk    <= fall_q;
              sdata   <= pick_bit(word_q, next_cnt, lsb_q, len24_q);
            end
          end
        end
        default: begin
          dev_latch <= '0;
          busy      <= 1'b0;
          sdata     <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // R7
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_en));
  // R8
  latch_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|dev_latch) |=> (dev_latch == '0));
  // R8
  latch_after_en_chk: assert property (@(posedge clk) disable iff (rst)
    (|dev_latch) |-> (dev_en == '0 && $past(dev_en) == dev_latch));
  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && start) |=> $stable(word_q));
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && tick && !phase_b) |=> $stable(sdata));
  // R5
  sclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && !tick) |=> $stable(sclk));
endmodule

// File: rtl/ser_word_loader.sv
module ser_word_loader
  import swl_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int HALF_DIV = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [15:0]        wr_data,
  output logic               busy,
  output logic               sclk,
  output logic               sdata,
  output logic [NUM_DEV-1:0] dev_en,
  output logic [NUM_DEV-1:0] dev_latch,
  output logic               bus_scl,
  output logic               bus_sda
);
  xfer_cfg_t            cfg;
  logic [WORD_BITS-1:0] word;
  logic                 start;
  logic                 run;
  logic                 tick;

  swl_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .word(word), .man_scl(bus_scl), .man_sda(bus_sda), .start(start)
  );

  swl_timebase #(.HALF_DIV(HALF_DIV)) u_tb (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  swl_engine #(.NUM_DEV(NUM_DEV)) u_eng (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .word(word), .tick(tick),
    .run(run), .busy(busy), .sclk(sclk), .sdata(sdata),
    .dev_en(dev_en), .dev_latch(dev_latch)
  );
endmodule

// File: tb/ser_word_loader_bench.sv
module ser_word_loader_bench;
  localparam int NDEV = 3;
  localparam int HD   = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = '0;
  logic [15:0]     wr_data = '0;
  logic            busy, sclk, sdata, bus_scl, bus_sda;
  logic [NDEV-1:0] dev_en, dev_latch;

  ser_word_loader #(.NUM_DEV(NDEV), .HALF_DIV(HD)) u_ser_word_loader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .sclk(sclk), .sdata(sdata), .dev_en(dev_en),
    .dev_latch(dev_latch), .bus_scl(bus_scl), .bus_sda(bus_sda)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          dev;
    bit          lsb;
    bit          fall;
    bit          l24;
    logic [23:0] bits;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0, n_done = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mkctrl(input int dev, input bit lsb, input bit fall,
                                         input bit l24, input bit mscl, input bit msda);
    return {8'(dev), 3'b000, msda, mscl, l24, fall, lsb};
  endfunction

  // Model of the held word and the active configuration
  logic [15:0] m_lo = '0;
  logic [7:0]  m_hi = '0;
  int          m_dev = 0;
  bit          m_lsb = 0, m_fall = 0, m_l24 = 0;

  task automatic set_ctrl(input int dev, input bit lsb, input bit fall, input bit l24,
                          input bit mscl, input bit msda);
    m_dev = dev; m_lsb = lsb; m_fall = fall; m_l24 = l24;
    wr(2'd0, mkctrl(dev, lsb, fall, l24, mscl, msda));
    repeat (3) @(negedge clk);
  endtask

  task automatic go();
    exp_t it;
    logic [23:0] w;
    int n;
    w = {m_hi, m_lo};
    n = m_l24 ? 24 : 16;
    it.dev = m_dev; it.lsb = m_lsb; it.fall = m_fall; it.l24 = m_l24; it.bits = '0;
    for (int i = 0; i < n; i++) it.bits[i] = m_lsb ? w[i] : w[n-1-i];
    exp_q.push_back(it);
    wr(2'd3, 16'h0000);
  endtask

  task automatic wait_done(input int target);
    while (n_done < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor
  bit          in_x = 0;
  exp_t        cur;
  int          busy_cnt, en_cnt, latch_cnt, bad_sel, edges, unstable;
  logic [23:0] got;
  logic        prev_sclk, held_bit;

  always @(negedge clk) begin
    if (!rst) begin
      if (!in_x && busy) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected transfer started", 1, 0);
          cur.dev = 0; cur.lsb = 0; cur.fall = 0; cur.l24 = 0; cur.bits = '0;
        end else cur = exp_q.pop_front();
        in_x = 1; busy_cnt = 0; en_cnt = 0; latch_cnt = 0; bad_sel = 0;
        edges = 0; unstable = 0; got = '0; prev_sclk = cur.fall; held_bit = 1'b0;
      end
      if (in_x) begin
        logic [NDEV-1:0] esel;
        esel = (cur.dev < NDEV) ? NDEV'(1 << cur.dev) : '0;
        if (busy) begin
          busy_cnt++;
          if (dev_en != 0) begin
            if (dev_en == esel) en_cnt++; else bad_sel++;
          end
          if (dev_latch != 0) begin
            if (dev_latch == esel) latch_cnt++; else bad_sel++;
          end
          if (sclk != prev_sclk && sclk == !cur.fall) begin
            if (edges < 24) got[edges] = sdata;
            held_bit = sdata;
            edges++;
          end else if (sclk == !cur.fall && sdata != held_bit) unstable++;
          prev_sclk = sclk;
        end else begin
          int n;
          n = cur.l24 ? 24 : 16;
          chk(got == cur.bits, "R4/R6/R11", "bit sequence", int'(got), int'(cur.bits));
          chk(edges == n, "R6", "sampling edge count", edges, n);
          chk(unstable == 0, "R5", "sdata moved while sclk active", unstable, 0);
          chk(sclk == cur.fall, "R5", "sclk idle level", int'(sclk), int'(cur.fall));
          chk(busy_cnt == 2*n*HD + 1, "R9", "busy width", busy_cnt, 2*n*HD + 1);
          chk(en_cnt == ((cur.dev < NDEV) ? 2*n*HD : 0), "R7", "select width",
              en_cnt, (cur.dev < NDEV) ? 2*n*HD : 0);
          chk(latch_cnt == ((cur.dev < NDEV) ? 1 : 0), "R8", "latch pulse count",
              latch_cnt, (cur.dev < NDEV) ? 1 : 0);
          chk(bad_sel == 0, "R7", "wrong device line", bad_sel, 0);
          in_x = 0;
          n_done++;
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R9", "watchdog expired", n_done, -1);
    finish_run();
  end

  initial begin
    int quiet;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy after reset", int'(busy), 0);
    chk(dev_en == 0 && dev_latch == 0, "R1", "select/latch after reset",
        int'({dev_en, dev_latch}), 0);
    chk(sclk == 0, "R1", "sclk after reset", int'(sclk), 0);
    chk(bus_scl == 1 && bus_sda == 1, "R1", "bus lines after reset",
        int'({bus_scl, bus_sda}), 3);

    // R3 R4 R6: device 1, MSB-first, rising edge, 16 bits
    set_ctrl(1, 0, 0, 0, 1, 1);
    m_lo = 16'hA5C3; wr(2'd1, m_lo);
    go(); wait_done(1);

    // R2: high register written before low, device 2, LSB-first, falling, 24 bits
    set_ctrl(2, 1, 1, 1, 1, 1);
    chk(sclk == 1, "R5", "idle level follows falling-edge setting", int'(sclk), 1);
    m_hi = 8'h5A; wr(2'd2, 16'h5A77);
    m_lo = 16'h1234; wr(2'd1, m_lo);
    go(); wait_done(2);

    // R11: resend with no new data
    go(); wait_done(3);

    // R10: start during a transfer, device 0, MSB-first, falling, 24 bits
    set_ctrl(0, 0, 1, 1, 1, 1);
    go();
    repeat (6) @(negedge clk);
    m_lo = 16'hFFFF; wr(2'd1, m_lo);
    wr(2'd3, 16'h0000);
    wait_done(4);
    quiet = 0;
    repeat (40) begin
      @(negedge clk);
      if (busy) quiet++;
    end
    chk(quiet == 0 && exp_q.size() == 0, "R10", "no transfer after ignored start", quiet, 0);

    // R11: new low word picked up by next start
    go(); wait_done(5);

    // R7 R8: out-of-range device index, LSB-first, rising, 16 bits
    set_ctrl(3, 1, 0, 0, 1, 1);
    go(); wait_done(6);

    // R12: manual lines
    set_ctrl(0, 0, 0, 0, 0, 1);
    chk(bus_scl == 0 && bus_sda == 1, "R12", "manual lines 0/1", int'({bus_scl, bus_sda}), 1);
    set_ctrl(1, 0, 0, 1, 1, 0);
    chk(bus_scl == 1 && bus_sda == 0, "R12", "manual lines 1/0", int'({bus_scl, bus_sda}), 2);
    go(); wait_done(7);
    chk(bus_scl == 1 && bus_sda == 0, "R12", "manual lines untouched by transfer",
        int'({bus_scl, bus_sda}), 2);

    finish_run();
  end
endmodule